// File: doc/BRIEF.md
# Gap-Modulated Tag Block Writer

This block sequences the carrier of a low-frequency reader so that one 32-bit word reaches a tag block through gap modulation. A single start strobe begins the sequence. The block first holds the carrier on so the antenna settles and the tag powers up. It then opens a start gap and sends a fixed 38-bit frame. In that frame, the carrier-on time before each fixed off-gap tells the tag whether the bit is a zero or a one. After the frame, the carrier stays on through a programming hold.

All timing is counted in microseconds. The microsecond unit comes from a clock divider whose ratio is a parameter. Every duration is also a parameter, so a small build can run the whole sequence in a few hundred clocks. The word and the address are captured when the strobe is accepted. The surrounding logic watches busy and a one-clock done pulse.

Top module: `lf_gap_writer`

## Requirements
- R1: While idle, and during and after reset, carrier_on_o is 1, busy_o is 0 and done_o is 0.
- R2: A start_i seen high at a clock edge while idle raises busy_o from the next cycle. The carrier then stays on for SETTLE_US microseconds.
- R3: After the settle period, the carrier is off for START_GAP_US microseconds.
- R4: A frame bit of 0 gives ZERO_US microseconds of carrier on, and a bit of 1 gives ONE_US. Every bit is followed by GAP_US microseconds of carrier off.
- R5: The frame holds 38 bits sent in this order: opcode 1 then 0, lock bit 0, the 32 data bits from bit 31 down to bit 0, then the 3 address bits from bit 2 down to bit 0.
- R6: After the gap of the last address bit, the carrier is on for PROG_US microseconds.
- R7: done_o is high for exactly one cycle: the first cycle after the programming hold, in which busy_o is already 0. It then returns to 0.
- R8: A start_i pulse while busy_o is 1 has no effect on the carrier waveform or the handshake.
- R9: One microsecond is exactly CLK_PER_US clock cycles. The divider phase restarts with each accepted start, so each phase of D microseconds lasts D*CLK_PER_US cycles.
- R10: data_i and blk_addr_i are sampled only at the accepted start. Later changes do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Write request strobe |
| data_i | input | DATA_W (32) | Word to write |
| blk_addr_i | input | ADDR_W (3) | Target block address |
| carrier_on_o | output | 1 | 1 = carrier field on, 0 = gap |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at completion |

## Verification
The bench writes several words: all zeros, all ones, alternating patterns, and the two extreme addresses. A design that mixed up the zero and one mark lengths, or reversed the order of a field, would show a carrier edge in the wrong cycle. A design with a free-running divider would shift every phase by up to CLK_PER_US-1 cycles. A second strobe with a new word is pulsed in the middle of a frame, and the inputs are changed while busy. A design that restarted or re-latched would change the waveform. The strobe is also held high across completion. A design that stretched done, or that ignored a start in the done cycle, would break the back-to-back timing.

// File: rtl/lfw_pkg.sv
`timescale 1ns/1ps
package lfw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_SGAP   = 3'd2,
      ST_MARK   = 3'd3,
      ST_SPACE  = 3'd4,
      ST_PROG   = 3'd5
   } wr_state_t;

   localparam logic [1:0] WR_OPCODE = 2'b10;
   localparam logic       WR_LOCK   = 1'b0;
   localparam int         HDR_W     = 3;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/lfw_tick_gen.sv
`timescale 1ns/1ps
module lfw_tick_gen #(
   parameter int CLK_PER_US = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("CLK_PER_US must be at least 1");
      end
      if (CLK_PER_US == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int DW = $clog2(CLK_PER_US);
         localparam logic [DW-1:0] DIV_LAST = DW'(CLK_PER_US - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               div_q <= '0;
            end else if (div_q == DIV_LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = run && (div_q == DIV_LAST);
      end
   endgenerate
endmodule

// File: rtl/lfw_frame_reg.sv
`timescale 1ns/1ps
module lfw_frame_reg
   import lfw_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter int FRAME_W = HDR_W + DATA_W + ADDR_W,
   parameter int IDX_W   = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DATA_W-1:0]  data,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [IDX_W-1:0]   idx,
   output logic [FRAME_W-1:0] frame_q,
   output logic               cur_bit
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(FRAME_W - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (load) begin
         frame_q <= {WR_OPCODE, WR_LOCK, data, addr};
      end
   end

   assign cur_bit = frame_q[TOP_IDX - idx];
endmodule

// File: rtl/lfw_phase_seq.sv
`timescale 1ns/1ps
module lfw_phase_seq
   import lfw_pkg::*;
#(
   parameter int SETTLE_US    = 150000,
   parameter int START_GAP_US = 250,
   parameter int ZERO_US      = 144,
   parameter int ONE_US       = 400,
   parameter int GAP_US       = 160,
   parameter int PROG_US      = 20000,
   parameter int FRAME_W      = 38,
   parameter int IDX_W        = $clog2(FRAME_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             cur_bit,
   output wr_state_t        state,
   output logic             load,
   output logic             done,
   output logic [IDX_W-1:0] bit_idx
);
   localparam int MAX_US = max_of(max_of(max_of(SETTLE_US, START_GAP_US),
                                         max_of(ZERO_US, ONE_US)),
                                  max_of(GAP_US, PROG_US));
   localparam int CW = $clog2(MAX_US + 1);
   localparam logic [CW-1:0] END_SETTLE = CW'(SETTLE_US - 1);
   localparam logic [CW-1:0] END_SGAP   = CW'(START_GAP_US - 1);
   localparam logic [CW-1:0] END_ZERO   = CW'(ZERO_US - 1);
   localparam logic [CW-1:0] END_ONE    = CW'(ONE_US - 1);
   localparam logic [CW-1:0] END_GAP    = CW'(GAP_US - 1);
   localparam logic [CW-1:0] END_PROG   = CW'(PROG_US - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

   generate
      if (SETTLE_US < 1 || START_GAP_US < 1 || ZERO_US < 1 ||
          ONE_US < 1 || GAP_US < 1 || PROG_US < 1) begin : g_bad_len
         $error("every duration must be at least one microsecond");
      end
      if (ZERO_US == ONE_US) begin : g_bad_marks
         $error("zero and one marks must differ");
      end
   endgenerate

   logic [CW-1:0] us_cnt;
   logic [CW-1:0] span_end;
   logic          phase_end;

   always_comb begin
      unique case (state)
         ST_SETTLE: span_end = END_SETTLE;
         ST_SGAP:   span_end = END_SGAP;
         ST_MARK:   span_end = cur_bit ? END_ONE : END_ZERO;
         ST_SPACE:  span_end = END_GAP;
         ST_PROG:   span_end = END_PROG;
         default:   span_end = '0;
      endcase
   end

   assign phase_end = tick && (us_cnt == span_end);
   assign load      = (state == ST_IDLE) && start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         us_cnt  <= '0;
         bit_idx <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == ST_IDLE) begin
            if (start) begin
               state   <= ST_SETTLE;
               us_cnt  <= '0;
               bit_idx <= '0;
            end
         end else if (phase_end) begin
            us_cnt <= '0;
            unique case (state)
               ST_SETTLE: state <= ST_SGAP;
               ST_SGAP:   state <= ST_MARK;
               ST_MARK:   state <= ST_SPACE;
               ST_SPACE: begin
                  if (bit_idx == LAST_IDX) begin
                     state <= ST_PROG;
                  end else begin
                     state   <= ST_MARK;
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
               ST_PROG: begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end else if (tick) begin
            us_cnt <= us_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lf_gap_writer.sv
`timescale 1ns/1ps
module lf_gap_writer
   import lfw_pkg::*;
#(
   parameter int CLK_PER_US   = 200,
   parameter int SETTLE_US    = 150000,
   parameter int START_GAP_US = 250,
   parameter int ZERO_US      = 144,
   parameter int ONE_US       = 400,
   parameter int GAP_US       = 160,
   parameter int PROG_US      = 20000,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] blk_addr_i,
   output logic              carrier_on_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int FRAME_W = HDR_W + DATA_W + ADDR_W;
   localparam int IDX_W   = $clog2(FRAME_W);

   wr_state_t          st;
   logic               tick;
   logic               cur_bit;
   logic               load;
   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   bit_idx;

   lfw_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_o),
      .tick (tick)
   );

   lfw_frame_reg #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .FRAME_W(FRAME_W),
      .IDX_W  (IDX_W)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .data   (data_i),
      .addr   (blk_addr_i),
      .idx    (bit_idx),
      .frame_q(frame_q),
      .cur_bit(cur_bit)
   );

   lfw_phase_seq #(
      .SETTLE_US   (SETTLE_US),
      .START_GAP_US(START_GAP_US),
      .ZERO_US     (ZERO_US),
      .ONE_US      (ONE_US),
      .GAP_US      (GAP_US),
      .PROG_US     (PROG_US),
      .FRAME_W     (FRAME_W),
      .IDX_W       (IDX_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .tick   (tick),
      .cur_bit(cur_bit),
      .state  (st),
      .load   (load),
      .done   (done_o),
      .bit_idx(bit_idx)
   );

   assign busy_o       = (st != ST_IDLE);
   assign carrier_on_o = !((st == ST_SGAP) || (st == ST_SPACE));
endmodule

// File: rtl/lfw_checker.sv
`timescale 1ns/1ps
module lfw_checker #(
   parameter int FRAME_W = 38,
   parameter int IDX_W   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               carrier_on_o,
   input logic               busy_o,
   input logic               done_o,
   input logic [FRAME_W-1:0] frame_q,
   input logic [IDX_W-1:0]   bit_idx
);
   p_idle_carrier_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> carrier_on_o);

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && carrier_on_o));

   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx <= IDX_W'(FRAME_W - 1));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   p_frame_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(frame_q));
endmodule

bind lf_gap_writer lfw_checker #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .carrier_on_o(carrier_on_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .frame_q     (frame_q),
   .bit_idx     (bit_idx)
);

// File: tb/test_lf_gap_writer.sv
`timescale 1ns/1ps
module test_lf_gap_writer;
   localparam int CPU = 2, SET = 10, SG = 5, Z = 3, O = 7, G = 4, PR = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] data_i = '0;
   logic [2:0]  blk_addr_i = '0;
   logic        carrier_on_o, busy_o, done_o;

   always #2.5 clk = ~clk;

   lf_gap_writer #(
      .CLK_PER_US(CPU), .SETTLE_US(SET), .START_GAP_US(SG), .ZERO_US(Z),
      .ONE_US(O), .GAP_US(G), .PROG_US(PR), .DATA_W(32), .ADDR_W(3)
   ) i_lf_gap_writer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
      .blk_addr_i(blk_addr_i), .carrier_on_o(carrier_on_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   typedef struct {
      logic  busy;
      logic  car;
      logic  done;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   cmp_on = 1'b0;

   task automatic chk(input logic got, input logic want, input string tag, input string what);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, got, want);
      end
   endtask

   task automatic push(input int cycles, input logic car, input string tag);
      for (int k = 0; k < cycles; k++) exp_q.push_back('{1'b1, car, 1'b0, tag});
   endtask

   // Reference model: builds the expected waveform when a start is taken.
   always @(posedge clk) begin
      if (rst_n && start_i && exp_q.size() == 0 && cmp_on) begin
         logic [37:0] fr;
         fr = {2'b10, 1'b0, data_i, blk_addr_i};
         push(SET * CPU, 1'b1, "R2 R9");
         push(SG * CPU, 1'b0, "R3");
         for (int b = 37; b >= 0; b--) begin
            push((fr[b] ? O : Z) * CPU, 1'b1, "R4 R5 R10");
            push(G * CPU, 1'b0, "R4");
         end
         push(PR * CPU, 1'b1, "R6");
         exp_q.push_back('{1'b0, 1'b1, 1'b1, "R7"});
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         exp_t e;
         if (exp_q.size() != 0) e = exp_q.pop_front();
         else e = '{1'b0, 1'b1, 1'b0, "R1 R8"};
         chk(busy_o, e.busy, e.tag, "busy");
         chk(carrier_on_o, e.car, e.tag, "carrier");
         chk(done_o, e.done, e.tag, "done");
      end
   end

   task automatic wait_idle();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic write_word(input logic [31:0] d, input logic [2:0] a);
      @(posedge clk); #1;
      start_i = 1'b1; data_i = d; blk_addr_i = a;
      @(posedge clk); #1;
      start_i = 1'b0;
      wait_idle();
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(carrier_on_o, 1'b1, "R1", "carrier in reset");
      chk(busy_o, 1'b0, "R1", "busy in reset");
      chk(done_o, 1'b0, "R1", "done in reset");
      @(posedge clk); #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      repeat (4) @(negedge clk);

      write_word(32'h0000_0000, 3'd0);
      write_word(32'hFFFF_FFFF, 3'd7);
      write_word(32'hA5A5_0F0F, 3'd5);

      // R8 and R10: strobe and input changes in mid-frame
      @(posedge clk); #1;
      start_i = 1'b1; data_i = 32'h1234_5678; blk_addr_i = 3'd2;
      @(posedge clk); #1;
      start_i = 1'b0; data_i = 32'hDEAD_BEEF; blk_addr_i = 3'd6;
      repeat (150) @(posedge clk); #1;
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0; data_i = 32'h0F0F_F0F0;
      wait_idle();

      // R7: start held through completion, restart in the done cycle
      @(posedge clk); #1;
      start_i = 1'b1; data_i = 32'h5555_AAAA; blk_addr_i = 3'd1;
      @(negedge clk);
      while (done_o !== 1'b1) @(negedge clk);
      @(posedge clk); #1;
      start_i = 1'b0; data_i = 32'h0000_0001; blk_addr_i = 3'd4;
      wait_idle();

      chk(busy_o, 1'b0, "R7", "final busy");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule